// File: doc/BRIEF.md
# Battery Lifetime Statistics Tracker

This block keeps the long-term history of a single battery cell. Once per minute, while the device is in operational mode, it advances an elapsed-time counter and adds the present cell temperature into an accumulator. It also keeps four peak-hold registers: the highest and lowest cell voltage and the highest and lowest cell temperature. These registers take a new value each time a fresh measurement arrives. A cycle counter sums the charge-percentage decrement events it is given and adds one each time that sum reaches a full 100 %.

All history counters saturate. None of them wraps. In sleep mode every piece of history state is held. Software reaches the registers through a word-wide write port and a registered read port. A write to a counter word sets the value from which counting resumes. A write to a peak register sets a new reference for later samples to beat. The cycle counter can be read but not written.

Top module: `batt_history_tracker`

## Requirements
- R1: In operational mode (`op_mode`=1), each `minute_tick` adds 1 to the 24-bit run-time counter. Address 0 reads bits 15:0 of the counter. Address 1 reads bits 23:16 in `rd_data[7:0]`, and the upper bits of `rd_data` read as zero.
- R2: The run-time counter stops at 0xFFFFFF and stays there on later ticks.
- R3: In operational mode, each `minute_tick` adds `cell_temp` to a 32-bit accumulator. The accumulator stops at 0xFFFFFFFF. Address 2 reads bits 15:0 and address 3 reads bits 31:16.
- R4: While `op_mode`=0, ticks, measurements and decrement events change no counter, accumulator or peak register.
- R5: A write to addresses 0 to 3 replaces the addressed 16-bit word, or for address 1 only bits 23:16 from `wr_data[7:0]`. The counter skips its increment in that cycle and later counts resume from the written value.
- R6: After reset the two counters and the cycle counter read 0. Max voltage (address 5) reads 0x0000, min voltage (address 6) 0x1388, max temperature (address 7) 0x0980 and min temperature (address 8) 0x0DCC.
- R7: A `meas_valid` strobe in operational mode loads `meas_volt` into the max-voltage register when it is larger and into the min-voltage register when it is smaller. `cell_temp` is handled the same way for the temperature pair.
- R8: A write to addresses 5 to 8 loads `wr_data` as the new held value, and later samples are compared against it.
- R9: Each `dec_valid` in operational mode adds `dec_amt` to an internal sum. Any amount above 100 counts as 100. When the sum reaches 100, the cycle counter (address 4) adds 1 and 100 is subtracted, so the remainder carries forward.
- R10: The cycle counter stops at 0xFFFF, and writes to address 4 have no effect.
- R11: `rd_data` is registered and shows the addressed register one clock after `reg_addr` is presented. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 1 | 1 = operational, 0 = sleep |
| minute_tick | input | 1 | One-cycle pulse once per minute |
| meas_valid | input | 1 | New voltage/temperature sample strobe |
| meas_volt | input | DW (16) | Cell voltage sample in mV |
| cell_temp | input | DW (16) | Current cell temperature in 0.1 K |
| dec_valid | input | 1 | Charge-percentage decrement event |
| dec_amt | input | DEC_W (7) | Decrement size in percent |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| wr_data | input | DW (16) | Write data |
| rd_data | output | DW (16) | Registered read data |

## Verification
A wrong counter or peak value stays in its register until software overwrites it. The error therefore appears on `rd_data` one clock after that address is selected, and it keeps appearing on every later read. A lost carry in the cycle-tracking sum does not show at the moment it happens. It shows only when the cycle count falls behind, which can take several decrement events, so the bench reads back all nine registers at intervals during random traffic. Saturation faults show only near the limits, so the limits are reached through writes, or for the cycle counter through a long run of decrement events.

// File: rtl/batt_hist_pkg.sv
package batt_hist_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_RT_LO = 4'd0,
    A_RT_HI = 4'd1,
    A_TA_LO = 4'd2,
    A_TA_HI = 4'd3,
    A_CYC   = 4'd4,
    A_VMAX  = 4'd5,
    A_VMIN  = 4'd6,
    A_TMAX  = 4'd7,
    A_TMIN  = 4'd8
  } hist_addr_e;

  localparam logic [15:0] VMAX_INIT = 16'h0000;
  localparam logic [15:0] VMIN_INIT = 16'h1388;
  localparam logic [15:0] TMAX_INIT = 16'h0980;
  localparam logic [15:0] TMIN_INIT = 16'h0DCC;

  function automatic logic [15:0] peak_init(input int idx);
    case (idx)
      0:       return VMAX_INIT;
      1:       return VMIN_INIT;
      2:       return TMAX_INIT;
      default: return TMIN_INIT;
    endcase
  endfunction
endpackage

// File: rtl/hist_sat_counter.sv
module hist_sat_counter #(
  parameter int W  = 24,
  parameter int DW = 16,
  parameter int AW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_en,
  input  logic [AW-1:0] inc_amt,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  output logic [W-1:0]  cnt
);
  localparam int HW = W - DW;

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, cnt} + {{(W+1-AW){1'b0}}, inc_amt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_lo) begin
      cnt[DW-1:0] <= wr_data;
    end else if (wr_hi) begin
      cnt[W-1:DW] <= wr_data[HW-1:0];
    end else if (inc_en) begin
      cnt <= sum[W] ? '1 : sum[W-1:0];
    end
  end
endmodule

// File: rtl/hist_peak_hold.sv
module hist_peak_hold #(
  parameter int           W         = 16,
  parameter bit           TRACK_MAX = 1'b1,
  parameter logic [W-1:0] INIT      = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_en,
  input  logic [W-1:0] smp,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] held
);
  logic beyond;

  generate
    if (TRACK_MAX) begin : g_max
      assign beyond = smp > held;
    end else begin : g_min
      assign beyond = smp < held;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= INIT;
    end else if (wr) begin
      held <= wr_val;
    end else if (smp_en && beyond) begin
      held <= smp;
    end
  end
endmodule

// File: rtl/hist_cycle_tracker.sv
module hist_cycle_tracker #(
  parameter int CW   = 16,
  parameter int DW   = 7,
  parameter int FULL = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_en,
  input  logic [DW-1:0] dec_amt,
  output logic [CW-1:0] cycles
);
  localparam int SW = DW + 1;

  logic [DW-1:0] acc;
  logic [DW-1:0] amt_c;
  logic [SW-1:0] sum;
  logic [SW-1:0] rem;
  logic          wrap;

  always_comb begin
    amt_c = (dec_amt > DW'(FULL)) ? DW'(FULL) : dec_amt;
    sum   = {1'b0, acc} + {1'b0, amt_c};
    wrap  = sum >= SW'(FULL);
    rem   = sum - SW'(FULL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      cycles <= '0;
    end else if (dec_en) begin
      acc <= wrap ? rem[DW-1:0] : sum[DW-1:0];
      if (wrap && (cycles != '1)) begin
        cycles <= cycles + 1'b1;
      end
    end
  end
endmodule

// File: rtl/batt_history_tracker.sv
module batt_history_tracker
  import batt_hist_pkg::*;
#(
  parameter int RT_W  = 24,
  parameter int TA_W  = 32,
  parameter int CC_W  = 16,
  parameter int DW    = 16,
  parameter int DEC_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_mode,
  input  logic              minute_tick,
  input  logic              meas_valid,
  input  logic [DW-1:0]     meas_volt,
  input  logic [DW-1:0]     cell_temp,
  input  logic              dec_valid,
  input  logic [DEC_W-1:0]  dec_amt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data
);
  localparam int NPEAK = 4;

  logic [RT_W-1:0] rt_cnt;
  logic [TA_W-1:0] ta_cnt;
  logic [CC_W-1:0] cyc_cnt;
  logic [DW-1:0]   peak [NPEAK];
  logic            tick_en;

  assign tick_en = op_mode && minute_tick;

  hist_sat_counter #(.W(RT_W), .DW(DW), .AW(1)) u_runtime (
    .clk     (clk),
    .rst     (rst),
    .inc_en  (tick_en),
    .inc_amt (1'b1),
    .wr_lo   (wr_en && (reg_addr == A_RT_LO)),
    .wr_hi   (wr_en && (reg_addr == A_RT_HI)),
    .wr_data (wr_data),
    .cnt     (rt_cnt)
  );

  hist_sat_counter #(.W(TA_W), .DW(DW), .AW(DW)) u_temp_acc (
    .clk     (clk),
    .rst     (rst),
    .inc_en  (tick_en),
    .inc_amt (cell_temp),
    .wr_lo   (wr_en && (reg_addr == A_TA_LO)),
    .wr_hi   (wr_en && (reg_addr == A_TA_HI)),
    .wr_data (wr_data),
    .cnt     (ta_cnt)
  );

  hist_cycle_tracker #(.CW(CC_W), .DW(DEC_W), .FULL(100)) u_cycles (
    .clk     (clk),
    .rst     (rst),
    .dec_en  (op_mode && dec_valid),
    .dec_amt (dec_amt),
    .cycles  (cyc_cnt)
  );

  for (genvar g = 0; g < NPEAK; g++) begin : g_peak
    localparam bit           IS_MAX = (g % 2) == 0;
    localparam logic [DW-1:0] INIT  = DW'(peak_init(g));
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_VMAX) + g);
    hist_peak_hold #(.W(DW), .TRACK_MAX(IS_MAX), .INIT(INIT)) u_pk (
      .clk    (clk),
      .rst    (rst),
      .smp_en (op_mode && meas_valid),
      .smp    ((g < 2) ? meas_volt : cell_temp),
      .wr     (wr_en && (reg_addr == MY_ADDR)),
      .wr_val (wr_data),
      .held   (peak[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (reg_addr)
        A_RT_LO: rd_data <= rt_cnt[DW-1:0];
        A_RT_HI: rd_data <= DW'(rt_cnt[RT_W-1:DW]);
        A_TA_LO: rd_data <= ta_cnt[DW-1:0];
        A_TA_HI: rd_data <= DW'(ta_cnt[TA_W-1:DW]);
        A_CYC:   rd_data <= DW'(cyc_cnt);
        A_VMAX:  rd_data <= peak[0];
        A_VMIN:  rd_data <= peak[1];
        A_TMAX:  rd_data <= peak[2];
        A_TMIN:  rd_data <= peak[3];
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/batt_history_checker.sv
module batt_history_checker #(
  parameter int RT_W = 24,
  parameter int TA_W = 32,
  parameter int CC_W = 16,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            op_mode,
  input logic            minute_tick,
  input logic            dec_valid,
  input logic            wr_en,
  input logic [RT_W-1:0] rt_cnt,
  input logic [TA_W-1:0] ta_cnt,
  input logic [CC_W-1:0] cyc_cnt,
  input logic [DW-1:0]   vmax,
  input logic [DW-1:0]   vmin
);
  // R1: one step per operational tick below the limit
  a_r1_rt_step: assert property (@(posedge clk) disable iff (rst)
    (op_mode && minute_tick && !wr_en && rt_cnt != '1) |=> rt_cnt == $past(rt_cnt) + 1'b1);

  // R2: saturated run time stays at the limit
  a_r2_rt_sat: assert property (@(posedge clk) disable iff (rst)
    (rt_cnt == '1 && !wr_en) |=> rt_cnt == '1);

  // R4: sleep holds all history
  a_r4_sleep_freeze: assert property (@(posedge clk) disable iff (rst)
    (!op_mode && !wr_en) |=> ($stable(rt_cnt) && $stable(ta_cnt) && $stable(cyc_cnt)
                              && $stable(vmax) && $stable(vmin)));

  // R7: peaks only move outward without writes
  a_r7_vmax_mono: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> vmax >= $past(vmax));
  a_r7_vmin_mono: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> vmin <= $past(vmin));

  // R9: cycle count moves by at most one per event and not without one
  a_r9_cyc_step: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> (cyc_cnt == $past(cyc_cnt) || cyc_cnt == $past(cyc_cnt) + 1'b1));
  a_r9_cyc_idle: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> $stable(cyc_cnt));

  // R10: cycle count holds at its limit
  a_r10_cyc_sat: assert property (@(posedge clk) disable iff (rst)
    cyc_cnt == '1 |=> cyc_cnt == '1);
endmodule

bind batt_history_tracker batt_history_checker #(
  .RT_W(RT_W), .TA_W(TA_W), .CC_W(CC_W), .DW(DW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_mode     (op_mode),
  .minute_tick (minute_tick),
  .dec_valid   (dec_valid),
  .wr_en       (wr_en),
  .rt_cnt      (rt_cnt),
  .ta_cnt      (ta_cnt),
  .cyc_cnt     (cyc_cnt),
  .vmax        (peak[0]),
  .vmin        (peak[1])
);

// File: tb/sim_batt_history_tracker.sv
module sim_batt_history_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_mode = 1'b0;
  logic        minute_tick = 1'b0;
  logic        meas_valid = 1'b0;
  logic [15:0] meas_volt = '0;
  logic [15:0] cell_temp = 16'h0BA6;
  logic        dec_valid = 1'b0;
  logic [6:0]  dec_amt = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [23:0] m_rt;
  logic [31:0] m_ta;
  logic [15:0] m_cc;
  int          m_acc;
  logic [15:0] m_pk [4];

  always #2 clk = ~clk;

  batt_history_tracker u0 (
    .clk(clk), .rst(rst), .op_mode(op_mode), .minute_tick(minute_tick),
    .meas_valid(meas_valid), .meas_volt(meas_volt), .cell_temp(cell_temp),
    .dec_valid(dec_valid), .dec_amt(dec_amt), .wr_en(wr_en),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic model_reset();
    m_rt = '0; m_ta = '0; m_cc = '0; m_acc = 0;
    m_pk[0] = 16'h0000; m_pk[1] = 16'h1388; m_pk[2] = 16'h0980; m_pk[3] = 16'h0DCC;
  endtask

  // next state from the requirements, using the inputs now driven
  task automatic model_step();
    logic [32:0] s;
    int amt;
    logic [15:0] smp;
    if (wr_en && reg_addr == 4'd0)      m_rt[15:0] = wr_data;
    else if (wr_en && reg_addr == 4'd1) m_rt[23:16] = wr_data[7:0];
    else if (op_mode && minute_tick && m_rt != 24'hFFFFFF) m_rt = m_rt + 24'd1;
    if (wr_en && reg_addr == 4'd2)      m_ta[15:0] = wr_data;
    else if (wr_en && reg_addr == 4'd3) m_ta[31:16] = wr_data;
    else if (op_mode && minute_tick) begin
      s = {1'b0, m_ta} + {17'd0, cell_temp};
      m_ta = s[32] ? 32'hFFFFFFFF : s[31:0];
    end
    if (op_mode && dec_valid) begin
      amt = (dec_amt > 7'd100) ? 100 : int'(dec_amt);
      m_acc = m_acc + amt;
      if (m_acc >= 100) begin
        m_acc = m_acc - 100;
        if (m_cc != 16'hFFFF) m_cc = m_cc + 16'd1;
      end
    end
    for (int i = 0; i < 4; i++) begin
      smp = (i < 2) ? meas_volt : cell_temp;
      if (wr_en && reg_addr == 4'(5 + i)) m_pk[i] = wr_data;
      else if (op_mode && meas_valid) begin
        if ((i % 2) == 0 && smp > m_pk[i]) m_pk[i] = smp;
        if ((i % 2) == 1 && smp < m_pk[i]) m_pk[i] = smp;
      end
    end
  endtask

  function automatic logic [15:0] exp_word(input int a);
    case (a)
      0: return m_rt[15:0];
      1: return {8'h00, m_rt[23:16]};
      2: return m_ta[15:0];
      3: return m_ta[31:16];
      4: return m_cc;
      5: return m_pk[0];
      6: return m_pk[1];
      7: return m_pk[2];
      8: return m_pk[3];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic clear_strobes();
    minute_tick = 0; meas_valid = 0; dec_valid = 0; wr_en = 0;
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic read_chk(input int a, input string tag);
    logic [15:0] e;
    clear_strobes();
    reg_addr = 4'(a);
    e = exp_word(a);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rd_data, e);
    end
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 9; a++) read_chk(a, tag);
  endtask

  task automatic do_write(input int a, input logic [15:0] d);
    wr_en = 1; reg_addr = 4'(a); wr_data = d;
    step();
  endtask

  task automatic do_tick(input logic [15:0] t);
    minute_tick = 1; cell_temp = t;
    step();
  endtask

  task automatic do_meas(input logic [15:0] v, input logic [15:0] t);
    meas_valid = 1; meas_volt = v; cell_temp = t;
    step();
  endtask

  task automatic do_dec(input logic [6:0] a);
    dec_valid = 1; dec_amt = a;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R6 reset state, R11 registered read and unmapped addresses
    read_all("R6");
    read_chk(9, "R11");
    read_chk(15, "R11");

    // R1 and R3 basic counting
    op_mode = 1;
    for (int i = 0; i < 5; i++) do_tick(16'h0BA6);
    read_chk(0, "R1");
    read_chk(2, "R3");

    // R7 and R8 peak behaviour
    do_meas(16'h1000, 16'h0B00);
    do_meas(16'h0F00, 16'h0C00);
    read_all("R7");
    do_write(5, 16'h0800);
    do_meas(16'h0900, 16'h0B80);
    read_chk(5, "R8");
    do_write(8, 16'h0D00);
    read_chk(8, "R8");

    // R4 sleep freezes everything
    op_mode = 0;
    do_tick(16'h0DCC);
    do_meas(16'h1388, 16'h0980);
    do_meas(16'h0000, 16'h0DCC);
    do_dec(7'd100);
    read_all("R4");
    op_mode = 1;

    // R2 and R5 run-time saturation via writes
    do_write(0, 16'hFFFE);
    do_write(1, 16'h00FF);
    minute_tick = 1; wr_en = 1; reg_addr = 4'd0; wr_data = 16'hFFFD;
    step();
    read_chk(0, "R5");
    for (int i = 0; i < 4; i++) do_tick(16'h0BA6);
    read_chk(0, "R2");
    read_chk(1, "R2");

    // R3 accumulator saturation
    do_write(3, 16'hFFFF);
    do_write(2, 16'hF800);
    do_tick(16'h0DCC);
    read_chk(2, "R3");
    do_tick(16'h0DCC);
    read_chk(3, "R3");
    read_chk(2, "R3");

    // R9 remainder carry and clamp, R10 write ignored
    do_dec(7'd60);
    do_dec(7'd60);
    read_chk(4, "R9");
    do_dec(7'd120);
    do_dec(7'd79);
    read_chk(4, "R9");
    do_dec(7'd1);
    read_chk(4, "R9");
    do_write(4, 16'h1234);
    read_chk(4, "R10");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      op_mode     = ($urandom_range(0, 9) != 0);
      minute_tick = ($urandom_range(0, 3) == 0);
      meas_valid  = ($urandom_range(0, 2) == 0);
      meas_volt   = 16'($urandom_range(16'h09C4, 16'h1388));
      cell_temp   = 16'($urandom_range(16'h0980, 16'h0DCC));
      dec_valid   = ($urandom_range(0, 2) == 0);
      dec_amt     = 7'($urandom_range(0, 127));
      wr_en       = ($urandom_range(0, 19) == 0);
      reg_addr    = 4'($urandom_range(0, 10));
      wr_data     = 16'($urandom);
      step();
      if ((n % 250) == 249) read_all("R7");
    end
    read_all("R9");

    // R10 cycle counter saturation
    op_mode = 1;
    for (int n = 0; n < 65540; n++) do_dec(7'd100);
    read_chk(4, "R10");
    do_dec(7'd100);
    read_chk(4, "R10");

    finish_run();
  end
endmodule